// File: doc/BRIEF.md
# UART transmitter with break control

This block is the send side of one asynchronous serial channel. Characters go into an eight-entry queue through a write port. A shifter sends each one as a frame with one start bit, eight data bits sent least significant bit first, and one stop bit. The shifter moves only on a clock enable that pulses sixteen times per bit, so one bit lasts sixteen enable pulses. Two status outputs report whether the queue can take a character and whether the whole transmitter is empty.

Control arrives as single-cycle strobes: enable, disable, soft reset, start break and stop break. A disable stops new characters from being accepted, but the queue still drains onto the line. A break holds the line low. It begins only after every character queued ahead of it, and every character written while it waits, has been sent. Releasing the break gives the line at least one full bit time of marking before the next frame starts.

Top module: `uart_tx_brk`

## Requirements
- R1: After hardware reset the transmitter is disabled, `txd` is 1, and `tx_rdy` and `tx_emt` are both 0.
- R2: A frame is `txd`=0 for the start bit, then data bits 0 through 7 in that order, then `txd`=1 for the stop bit. Each bit lasts exactly 16 `tick16` pulses. Outside command effects, `txd` changes only in a cycle that follows a `tick16` pulse.
- R3: The queue holds 8 characters. `tx_rdy` is 1 exactly when the transmitter is enabled and fewer than 8 characters are waiting. A write made while 8 are waiting is dropped.
- R4: A write made while the transmitter is disabled is dropped and never reaches the line.
- R5: `tx_emt` is 1 only while the transmitter is enabled, the queue is empty and the line is idle. It is 0 while a frame, a break or the marking time after a break is in progress.
- R6: The cycle after `cmd_dis`, `tx_rdy` and `tx_emt` are 0. Characters already being sent or waiting in the queue are still sent in full.
- R7: The cycle after `cmd_en`, if the transmitter is idle with an empty queue and no break is pending, `tx_rdy` and `tx_emt` are 1.
- R8: `cmd_brk_on` is ignored while the transmitter is disabled. Enabling later does not start a break.
- R9: An accepted break drives `txd` to 0. This happens only after the frame in progress, the queued characters and any characters written while the break waits have all been sent. Once the queue is empty, `txd` is 0 within 32 `tick16` pulses.
- R10: `cmd_brk_off` during a break drives `txd` to 1 in the next cycle. The line then stays at 1 for at least 16 `tick16` pulses before the next start bit.
- R11: A `cmd_brk_off` that arrives before a pending break has begun cancels it. The line stays marking after the queue drains.
- R12: `cmd_rst` acts like a hardware reset. It empties the queue, cancels any frame or break, returns `txd` to 1 in the next cycle and disables the transmitter. It takes priority over every other strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick16 | input | 1 | Enable pulse, 16 per bit time |
| cmd_en | input | 1 | Strobe: enable the transmitter |
| cmd_dis | input | 1 | Strobe: disable the transmitter |
| cmd_rst | input | 1 | Strobe: soft reset of the transmitter |
| cmd_brk_on | input | 1 | Strobe: request a break |
| cmd_brk_off | input | 1 | Strobe: end or cancel a break |
| wr_en | input | 1 | Queue write strobe |
| wr_data | input | 8 | Character to queue |
| txd | output | 1 | Serial line, 1 = marking |
| tx_rdy | output | 1 | Queue can take a character |
| tx_emt | output | 1 | Queue and shifter are both empty |

## Verification
A fault in the shifter counters shows up within the first frame after it occurs. It appears as a bit whose width is not 16 pulses, or as a byte that differs from the one written. A queue pointer or count fault shows up as a lost, repeated or extra character once the queue drains, or as `tx_rdy` giving the wrong answer on the ninth write. A wrong break pending flag is visible within two bit times: either the line drops low while characters are still waiting, or it stays high when a break should already hold it low. Status faults around enable, disable and reset appear one cycle after the strobe.

// File: rtl/uart_tx_brk.sv
module uart_tx_brk #(
  parameter int DEPTH = 8,
  parameter int OSR   = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          cmd_en,
  input  logic          cmd_dis,
  input  logic          cmd_rst,
  input  logic          cmd_brk_on,
  input  logic          cmd_brk_off,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  output logic          txd,
  output logic          tx_rdy,
  output logic          tx_emt
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = (OSR > 1) ? $clog2(OSR) : 1;
  localparam int BW = (DW > 1) ? $clog2(DW) : 1;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_START = 3'd1,
    S_DATA  = 3'd2,
    S_STOP  = 3'd3,
    S_BRK   = 3'd4,
    S_MARK  = 3'd5
  } st_t;

  st_t           st;
  logic          en_q, brk_q;
  logic [CW-1:0] tcnt;
  logic [BW-1:0] bidx;
  logic [DW-1:0] shreg;
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;

  wire full    = (cnt == (AW+1)'(DEPTH));
  wire empty   = (cnt == '0);
  wire push    = wr_en && en_q && !full && !cmd_rst;
  wire pop     = tick16 && (st == S_IDLE) && !empty && !cmd_rst;
  wire brk_go  = tick16 && (st == S_IDLE) && empty && brk_q;
  wire bit_end = tick16 && (tcnt == CW'(OSR-1));

  assign txd    = (st == S_START || st == S_BRK) ? 1'b0 :
                  (st == S_DATA) ? shreg[0] : 1'b1;
  assign tx_rdy = en_q && !full;
  assign tx_emt = en_q && empty && (st == S_IDLE);

  always_ff @(posedge clk)
    if (push) mem[wptr] <= wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; en_q <= 1'b0; brk_q <= 1'b0;
      tcnt <= '0; bidx <= '0; shreg <= '0;
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else if (cmd_rst) begin
      st <= S_IDLE; en_q <= 1'b0; brk_q <= 1'b0;
      tcnt <= '0; bidx <= '0; shreg <= '0;
      wptr <= '0; rptr <= '0; cnt <= '0;
    end else begin
      if (cmd_dis)     en_q <= 1'b0;
      else if (cmd_en) en_q <= 1'b1;

      if (cmd_brk_off)                                brk_q <= 1'b0;
      else if (cmd_brk_on && en_q && st != S_BRK)     brk_q <= 1'b1;
      else if (brk_go)                                brk_q <= 1'b0;

      if (push) wptr <= (wptr == AW'(DEPTH-1)) ? '0 : wptr + 1'b1;
      if (pop)  rptr <= (rptr == AW'(DEPTH-1)) ? '0 : rptr + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;

      if (tick16 && st != S_IDLE && st != S_BRK)
        tcnt <= bit_end ? '0 : tcnt + 1'b1;

      unique case (st)
        S_IDLE: begin
          if (pop) begin
            shreg <= mem[rptr];
            tcnt  <= '0;
            st    <= S_START;
          end else if (brk_go) begin
            st <= S_BRK;
          end
        end
        S_START: if (bit_end) begin
          bidx <= '0;
          st   <= S_DATA;
        end
        S_DATA: if (bit_end) begin
          if (bidx == BW'(DW-1)) st <= S_STOP;
          else begin
            bidx  <= bidx + 1'b1;
            shreg <= shreg >> 1;
          end
        end
        S_STOP: if (bit_end) st <= S_IDLE;
        S_BRK: if (cmd_brk_off) begin
          tcnt <= '0;
          st   <= S_MARK;
        end
        S_MARK: if (bit_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/uart_tx_brk_chk.sv
module uart_tx_brk_chk #(
  parameter int DEPTH = 8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       tick16,
  input logic       wr_en,
  input logic       cmd_en,
  input logic       cmd_dis,
  input logic       cmd_rst,
  input logic       cmd_brk_on,
  input logic       cmd_brk_off,
  input logic       txd,
  input logic       tx_rdy,
  input logic       tx_emt,
  input logic       en_q,
  input logic       brk_q,
  input logic [$clog2(DEPTH):0] cnt,
  input logic [2:0] st
);
  localparam logic [2:0] IDLE = 3'd0;
  localparam logic [2:0] BRK  = 3'd4;

  // R2
  line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick16 && !cmd_rst && !cmd_brk_off) |=> $stable(txd));

  // R4
  drop_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && wr_en) |=> (cnt <= $past(cnt)));

  // R6
  dis_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_dis && !cmd_rst) |=> (!tx_rdy && !tx_emt));

  // R7
  en_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_en && !cmd_dis && !cmd_rst && !wr_en && cnt == '0 && st == IDLE && !brk_q)
      |=> (tx_rdy && tx_emt));

  // R8
  brk_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !brk_q && cmd_brk_on && !cmd_rst) |=> !brk_q);

  // R9
  brk_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == BRK) |-> ($past(cnt) == '0));

  // R10
  brk_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BRK && cmd_brk_off && !cmd_rst) |=> txd);

  // R12
  soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> (txd && !tx_rdy && !tx_emt && !brk_q));
endmodule

bind uart_tx_brk uart_tx_brk_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .wr_en(wr_en),
  .cmd_en(cmd_en), .cmd_dis(cmd_dis), .cmd_rst(cmd_rst),
  .cmd_brk_on(cmd_brk_on), .cmd_brk_off(cmd_brk_off),
  .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt),
  .en_q(en_q), .brk_q(brk_q), .cnt(cnt), .st(st)
);

// File: tb/uart_tx_brk_bench.sv
module uart_tx_brk_bench;
  localparam int TDIV = 3;
  localparam int FRM  = 160;

  logic clk = 0, rst_n = 0;
  logic tick16 = 0, cmd_en = 0, cmd_dis = 0, cmd_rst = 0;
  logic cmd_brk_on = 0, cmd_brk_off = 0, wr_en = 0;
  logic [7:0] wr_data = '0;
  logic txd, tx_rdy, tx_emt;

  uart_tx_brk u_uart_tx_brk (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .cmd_en(cmd_en),
    .cmd_dis(cmd_dis), .cmd_rst(cmd_rst), .cmd_brk_on(cmd_brk_on),
    .cmd_brk_off(cmd_brk_off), .wr_en(wr_en), .wr_data(wr_data),
    .txd(txd), .tx_rdy(tx_rdy), .tx_emt(tx_emt)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  int tk = 0, lows = 0, hi_run = 0, lead = 0, start_run = 0;
  int div = 0, m_n = 0;
  bit tick_on = 0, mon_on = 0;
  logic [FRM-1:0] fr;
  logic [7:0] expq [0:511];
  logic [7:0] rxq  [0:511];
  int exp_n = 0, rx_n = 0, cmp_i = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic bit frame_ok(input logic [FRM-1:0] f);
    bit ok = 1;
    for (int i = 0; i < 16; i++) if (f[i] !== 1'b0) ok = 0;
    for (int b = 0; b < 8; b++)
      for (int j = 0; j < 16; j++) if (f[16+16*b+j] !== f[16+16*b]) ok = 0;
    for (int i = 144; i < FRM; i++) if (f[i] !== 1'b1) ok = 0;
    return ok;
  endfunction

  function automatic logic [7:0] frame_byte(input logic [FRM-1:0] f);
    logic [7:0] v;
    for (int b = 0; b < 8; b++) v[b] = f[16+16*b];
    return v;
  endfunction

  always @(negedge clk) begin
    if (tick16) begin
      tk++;
      if (txd == 1'b0) lows++;
      if (!mon_on) m_n = 0;
      else if (m_n == 0) begin
        if (txd == 1'b0) begin
          start_run = hi_run;
          fr = '0;
          m_n = 1;
        end
      end else begin
        fr[m_n] = txd;
        m_n++;
        if (m_n == FRM) begin
          // R2 frame shape and 16-tick bit width
          chk(frame_ok(fr), "R2 frame shape", 0, 1);
          rxq[rx_n] = frame_byte(fr);
          rx_n++;
          lead = start_run;
          m_n = 0;
        end
      end
      hi_run = (txd == 1'b1) ? hi_run + 1 : 0;
    end
    tick16 <= tick_on && (div == TDIV-1);
    div = (div == TDIV-1) ? 0 : div + 1;
  end

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: cmd_en = 1;  1: cmd_dis = 1;  2: cmd_rst = 1;
      3: cmd_brk_on = 1;  default: cmd_brk_off = 1;
    endcase
    @(negedge clk);
    cmd_en = 0; cmd_dis = 0; cmd_rst = 0; cmd_brk_on = 0; cmd_brk_off = 0;
  endtask

  task automatic wr(input logic [7:0] d, input bit keep);
    @(negedge clk);
    wr_en = 1; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (keep) begin expq[exp_n] = d; exp_n++; end
  endtask

  task automatic wait_ticks(input int n);
    int t0 = tk;
    wait (tk >= t0 + n);
    @(negedge clk);
  endtask

  task automatic wait_emt();
    wait (tx_emt == 1'b1);
    @(negedge clk);
  endtask

  task automatic compare_rx(input string tag);
    chk(rx_n == exp_n, tag, rx_n, exp_n);
    while (cmp_i < exp_n && cmp_i < rx_n) begin
      chk(rxq[cmp_i] == expq[cmp_i], tag, rxq[cmp_i], expq[cmp_i]);
      cmp_i++;
    end
    cmp_i = exp_n;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(txd == 1, "R1 txd", txd, 1);
    chk(tx_rdy == 0, "R1 tx_rdy", tx_rdy, 0);
    chk(tx_emt == 0, "R1 tx_emt", tx_emt, 0);

    // R4 write while disabled
    tick_on = 1; mon_on = 1;
    wr(8'h55, 0);
    lows = 0;
    wait_ticks(40);
    chk(lows == 0, "R4 disabled write reached line", lows, 0);
    chk(tx_emt == 0, "R4 tx_emt disabled", tx_emt, 0);

    // R7 enable from idle
    strobe(0);
    chk(tx_rdy == 1 && tx_emt == 1, "R7 status after enable", {tx_rdy, tx_emt}, 3);

    // R3 fill past depth with ticks held off
    tick_on = 0;
    wait_ticks(0);
    for (int i = 0; i < 10; i++) wr(8'(8'hA0 + i), i < 8);
    chk(tx_rdy == 0, "R3 tx_rdy when full", tx_rdy, 0);
    chk(tx_emt == 0, "R5 tx_emt with queue", tx_emt, 0);
    tick_on = 1;
    wait_emt();
    compare_rx("R3 depth and order");

    // R2 random bursts
    for (int n = 0; n < 12; n++) begin
      int len = 1 + int'($urandom_range(7));
      tick_on = $urandom_range(1);
      for (int i = 0; i < len; i++) begin
        wr(8'($urandom), 1);
        repeat ($urandom_range(5)) @(negedge clk);
      end
      tick_on = 1;
      wait_emt();
      compare_rx("R2 random burst data");
      chk(tx_rdy == 1, "R3 tx_rdy after drain", tx_rdy, 1);
    end

    // R6 disable with characters queued
    tick_on = 0;
    for (int i = 0; i < 3; i++) wr(8'(8'h30 + i), 1);
    strobe(1);
    chk(tx_rdy == 0 && tx_emt == 0, "R6 status after disable", {tx_rdy, tx_emt}, 0);
    wr(8'hEE, 0);
    tick_on = 1;
    wait (rx_n >= exp_n);
    wait_ticks(200);
    compare_rx("R6 queued characters still sent");
    strobe(0);
    chk(tx_rdy == 1 && tx_emt == 1, "R7 status after re-enable", {tx_rdy, tx_emt}, 3);

    // R8 break request while disabled
    strobe(1);
    strobe(3);
    strobe(0);
    lows = 0;
    wait_ticks(48);
    chk(lows == 0, "R8 break while disabled", lows, 0);
    chk(tx_emt == 1, "R8 tx_emt stays idle", tx_emt, 1);

    // R9 break from empty
    mon_on = 0;
    strobe(3);
    wait_ticks(32);
    chk(txd == 0, "R9 break from empty", txd, 0);
    chk(tx_emt == 0, "R5 tx_emt during break", tx_emt, 0);
    lows = 0;
    wait_ticks(64);
    chk(lows == 64, "R9 break held", lows, 64);

    // R10 stop break then a character
    strobe(4);
    chk(txd == 1, "R10 line marking after stop", txd, 1);
    mon_on = 1;
    wr(8'h5A, 1);
    wait_emt();
    compare_rx("R10 char after break");
    chk(lead >= 16, "R10 marking before start", lead, 16);

    // R9 break waits for queued and later characters
    tick_on = 0;
    for (int i = 0; i < 3; i++) wr(8'(8'hC0 + i), 1);
    strobe(3);
    tick_on = 1;
    wait_ticks(50);
    wr(8'hC7, 1);
    wait (rx_n >= exp_n);
    mon_on = 0;
    compare_rx("R9 characters before break");
    wait_ticks(32);
    chk(txd == 0, "R9 break after drain", txd, 0);
    strobe(4);
    wait_emt();
    mon_on = 1;

    // R11 cancel pending break
    tick_on = 0;
    wr(8'h11, 1);
    wr(8'h22, 1);
    strobe(3);
    strobe(4);
    tick_on = 1;
    wait_emt();
    compare_rx("R11 data before cancel");
    lows = 0;
    wait_ticks(48);
    chk(lows == 0, "R11 cancelled break", lows, 0);

    // R12 soft reset mid-frame with break pending
    for (int i = 0; i < 4; i++) wr(8'(8'h90 + i), 0);
    strobe(3);
    wait_ticks(60);
    mon_on = 0;
    strobe(2);
    chk(txd == 1, "R12 txd after soft reset", txd, 1);
    chk(tx_rdy == 0 && tx_emt == 0, "R12 status after soft reset", {tx_rdy, tx_emt}, 0);
    strobe(0);
    chk(tx_emt == 1, "R12 queue flushed", tx_emt, 1);
    lows = 0;
    wait_ticks(200);
    chk(lows == 0, "R12 nothing sent after reset", lows, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule